// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs one conversion at a time on an external 12-bit, eight-input serial converter. A request names an input (3-bit number) and whether it is measured single-ended or as a differential pair. The sequencer then opens a frame by pulling the active-low select line down. It divides the system clock into a serial clock and sends a self-framing control word on the data-to-converter line. It then reads the 12-bit result back from the converter's data line and presents it with a one-cycle done strobe.

Every frame is exactly 24 serial clocks long, counted 1 to 24. Clocks 1-8 carry the control word. Clock 9 carries no result bit. Clocks 10-21 carry the result, most significant bit first. Clocks 22-24 only pad the third byte and are not sampled. The serial clock rests low. The converter samples data on its rising edge, and the sequencer moves its own output on the falling edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, select is high (1), the serial clock is low, the data-to-converter line is low, busy is 0 and done is 0.
- R2: Each accepted request produces exactly 24 rising serial clock edges while select is low, and select returns high right after the falling edge that follows the 24th rising edge.
- R3: With DIV_HALF system clocks per serial half period, every high and low level of the serial clock inside a frame lasts exactly DIV_HALF system clocks, and the serial clock is low whenever select is high.
- R4: The control word is sent MSB first on clocks 1-8 as: bit 7 start bit = 1, bits 6:4 input number (bit 6 is the number's MSB), bit 3 = 0, bit 2 = 1 for single-ended or 0 for differential, bits 1:0 = 0. The data line changes only while the serial clock is low.
- R5: The data-to-converter line is low on every rising edge from clock 9 to clock 24, so no second start bit is seen.
- R6: The result equals the bits on the converter's data line at the rising edges of clocks 10 to 21, first sampled bit as MSB. The line's value on clock 9 and on clocks 22-24 has no effect on the result.
- R7: Done is high for exactly one system clock per frame, in the cycle select returns high. The result output holds its value except in a done cycle.
- R8: A request seen while busy is ignored: the running frame keeps its control word, and no new frame starts after it ends.
- R9: Busy goes high in the cycle after a request is accepted, stays high exactly while select is low, and is low again in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start request, taken only when idle |
| req_chan | input | 3 | Input number to convert |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | 12 | Last conversion result |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Converter select, active low |
| din | output | 1 | Serial data to the converter |
| dout | input | 1 | Serial data from the converter |

## Verification
The hardest condition to create is a converter that drives the data line on exactly the clocks the sequencer must ignore. The bench's converter model drives a 1 on clock 9 and on clocks 22-24, and drives the expected word on clocks 10-21. Any shift of the capture window by one clock therefore corrupts the word. A second hard case is a request arriving mid-frame. The bench holds req_valid high across the middle of a frame with a different input number, then checks that the control word already captured is unchanged and that select stays high after the frame ends.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

   localparam int BYTE_CLKS  = 8;
   localparam int FRAME_BYTES = 3;
endpackage

// File: rtl/adc_sclk_gen.sv
`timescale 1ns/1ps
module adc_sclk_gen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (DIV_HALF < 1) begin : g_bad_div
      $error("adc_sclk_gen: DIV_HALF must be at least 1");
   end

   if (DIV_HALF == 1) begin : g_direct
      logic unused_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) unused_q <= 1'b0;
         else        unused_q <= run;
      end
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (!run)           cnt_q <= '0;
         else if (cnt_q == LAST)  cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick = run && (cnt_q == LAST);

      p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LAST);
      p_div_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> (cnt_q == '0));
   end
endmodule

// File: rtl/adc_ctrl_byte.sv
`timescale 1ns/1ps
module adc_ctrl_byte #(
   parameter int CTRL_W = 8,
   parameter int CH_W   = 3
) (
   input  logic [CH_W-1:0]   chan,
   input  logic              single,
   output logic [CTRL_W-1:0] word_o
);
   localparam int PAD_W = CTRL_W - CH_W - 3;

   if (PAD_W < 0) begin : g_bad_fit
      $error("adc_ctrl_byte: control word too narrow for the input number");
   end

   if (PAD_W == 0) begin : g_nopad
      assign word_o = {1'b1, chan, 1'b0, single};
   end else begin : g_pad
      assign word_o = {1'b1, chan, 1'b0, single, {PAD_W{1'b0}}};
   end
endmodule

// File: rtl/adc_result_shift.sv
`timescale 1ns/1ps
module adc_result_shift #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [DATA_W-1:0] word
);
   if (DATA_W < 2) begin : g_bad_w
      $error("adc_result_shift: DATA_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[DATA_W-2:0], bit_in};
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
   parameter int DATA_W   = 12,
   parameter int CH_W     = 3,
   parameter int DIV_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CH_W-1:0]   req_chan,
   input  logic              req_single,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              sclk,
   output logic              cs_n,
   output logic              din,
   input  logic              dout
);
   import adc_seq_pkg::*;

   localparam int CTRL_W     = BYTE_CLKS;
   localparam int FRAME_CLKS = FRAME_BYTES * BYTE_CLKS;
   localparam int RES_FIRST  = CTRL_W + 2;
   localparam int RES_LAST   = CTRL_W + 1 + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_CLKS + 1);

   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_CLKS);
   localparam logic [CNT_W-1:0] CAP_LO    = CNT_W'(RES_FIRST - 1);
   localparam logic [CNT_W-1:0] CAP_HI    = CNT_W'(RES_LAST - 1);
   localparam logic [CNT_W-1:0] CTRL_DONE = CNT_W'(CTRL_W);

   if (RES_LAST > FRAME_CLKS) begin : g_bad_frame
      $error("adc_seq_ctrl: result does not fit in the frame");
   end

   seq_state_e          state_q;
   logic [CNT_W-1:0]    bit_cnt_q;
   logic [CTRL_W-1:0]   ctrl_q;
   logic [CTRL_W-1:0]   ctrl_new;
   logic [DATA_W-1:0]   shift_word;
   logic [DATA_W-1:0]   result_q;
   logic                sclk_q, cs_n_q, din_q, done_q;
   logic                tick, rise, fall, cap_en, run;

   assign run  = (state_q == ST_RUN);
   assign rise = tick && !sclk_q;
   assign fall = tick &&  sclk_q;
   assign cap_en = rise && (bit_cnt_q >= CAP_LO) && (bit_cnt_q <= CAP_HI);

   adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
   );

   adc_ctrl_byte #(.CTRL_W(CTRL_W), .CH_W(CH_W)) u_ctrl (
      .chan(req_chan), .single(req_single), .word_o(ctrl_new)
   );

   adc_result_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(cap_en), .bit_in(dout),
      .word(shift_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         ctrl_q    <= '0;
         result_q  <= '0;
         sclk_q    <= 1'b0;
         cs_n_q    <= 1'b1;
         din_q     <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q   <= ST_RUN;
                  cs_n_q    <= 1'b0;
                  sclk_q    <= 1'b0;
                  bit_cnt_q <= '0;
                  ctrl_q    <= ctrl_new;
                  din_q     <= ctrl_new[CTRL_W-1];
               end
            end
            ST_RUN: begin
               if (rise) begin
                  sclk_q    <= 1'b1;
                  bit_cnt_q <= bit_cnt_q + 1'b1;
               end else if (fall) begin
                  sclk_q <= 1'b0;
                  if (bit_cnt_q == CNT_LAST) begin
                     state_q  <= ST_IDLE;
                     cs_n_q   <= 1'b1;
                     done_q   <= 1'b1;
                     din_q    <= 1'b0;
                     result_q <= shift_word;
                  end else begin
                     din_q  <= ctrl_q[CTRL_W-2];
                     ctrl_q <= ctrl_q << 1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy   = run;
   assign done   = done_q;
   assign result = result_q;
   assign sclk   = sclk_q;
   assign cs_n   = cs_n_q;
   assign din    = din_q;

   p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sclk_q);
   p_frame_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt_q <= CNT_LAST);
   p_din_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_q && $past(sclk_q)) |-> $stable(din_q));
   p_din_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_q && ((bit_cnt_q > CTRL_DONE) || (bit_cnt_q == CTRL_DONE && !sclk_q)))
      |-> !din_q);
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(result_q));
   p_busy_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy != cs_n_q);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (cs_n_q && !busy));
   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !fall) |=> run);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [2:0]  req_chan;
   logic        req_single;
   logic        busy, done, sclk, cs_n, din;
   logic        dout;
   logic [11:0] result;

   always #2 clk = ~clk;

   adc_seq_ctrl #(.DATA_W(12), .CH_W(3), .DIV_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_single(req_single), .busy(busy), .done(done), .result(result),
      .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   int          ecnt = 0;
   logic [7:0]  ctrl_cap = '0;
   bit          din_bad = 0;
   bit          per_bad = 0;
   int          lvl_len = 0;
   logic        prev_s = 1'b0;
   logic [11:0] adc_word = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // frame monitor: clock count, control word capture, data line in result phase
   always @(negedge cs_n) begin
      ecnt = 0; ctrl_cap = '0; din_bad = 0; per_bad = 0;
   end
   always @(posedge sclk) begin
      ecnt++;
      if (ecnt <= 8) ctrl_cap = {ctrl_cap[6:0], din};
      else if (din)  din_bad = 1;
   end

   // serial clock level length monitor
   always @(negedge clk) begin
      if (!cs_n) begin
         if (sclk !== prev_s) begin
            if (lvl_len != HALF) per_bad = 1;
            lvl_len = 1;
         end else begin
            lvl_len++;
         end
      end else begin
         if (sclk) per_bad = 1;
         lvl_len = 0;
      end
      prev_s = sclk;
   end

   // converter model: drives 1 on the ignored clocks, the word on clocks 10..21
   initial begin
      dout = 1'b1;
      forever begin
         int nxt;
         @(negedge sclk);
         nxt = ecnt + 1;
         if (nxt >= 10 && nxt <= 21) dout = adc_word[21-nxt];
         else                        dout = 1'b1;
      end
   end

   task automatic run_frame(input logic [2:0] ch, input logic sg,
                            input logic [11:0] w, input bit poke);
      logic [7:0] exp_ctrl;
      int guard;
      exp_ctrl = {1'b1, ch, 1'b0, sg, 2'b00};
      adc_word = w;
      req_valid = 1'b1; req_chan = ch; req_single = sg;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy && !cs_n, "R9", "busy after accept", {busy, cs_n}, 2'b10);
      if (poke) begin
         repeat (10) @(negedge clk);
         req_valid = 1'b1; req_chan = ~ch; req_single = ~sg;
         repeat (30) @(negedge clk);
         req_valid = 1'b0;
      end
      guard = 0;
      while (!done && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      check(done, "R7", "done seen", done, 1);
      check(result == w, "R6", "result word", result, w);
      check(ecnt == 24, "R2", "rising edges per frame", ecnt, 24);
      check(ctrl_cap == exp_ctrl, poke ? "R8" : "R4", "control word", ctrl_cap, exp_ctrl);
      check(!din_bad, "R5", "data line low in result phase", din_bad, 0);
      check(!per_bad, "R3", "serial clock level length", per_bad, 0);
      check(!busy && cs_n, "R9", "idle in done cycle", {busy, cs_n}, 2'b01);
      @(negedge clk);
      check(!done, "R7", "done one cycle wide", done, 0);
      if (poke) begin
         repeat (15) @(negedge clk);
         check(cs_n && !busy, "R8", "no frame from request while busy", {busy, cs_n}, 2'b01);
      end else begin
         repeat (3) @(negedge clk);
      end
      check(result == w, "R7", "result held after done", result, w);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_chan = '0; req_single = 1'b0;
      repeat (3) @(negedge clk);
      check({cs_n, sclk, din, busy, done} == 5'b10000, "R1", "outputs in reset",
            {cs_n, sclk, din, busy, done}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      check({cs_n, sclk, din, busy, done} == 5'b10000, "R1", "outputs after reset",
            {cs_n, sclk, din, busy, done}, 5'b10000);
      check(result == 12'h000, "R1", "result after reset", result, 0);

      for (int ch = 0; ch < 8; ch++) begin
         for (int sg = 0; sg < 2; sg++) begin
            run_frame(3'(ch), 1'(sg), 12'((ch * 499 + sg * 1234 + 77) % 4096), 1'b0);
         end
      end
      run_frame(3'd7, 1'b0, 12'h000, 1'b0);
      run_frame(3'd0, 1'b1, 12'hFFF, 1'b0);
      run_frame(3'd5, 1'b1, 12'h800, 1'b0);
      run_frame(3'd2, 1'b0, 12'h001, 1'b0);
      run_frame(3'd3, 1'b1, 12'hA5A, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule